// File: doc/BRIEF.md
# Programmable Logic Macrocell with Selectable Register Type

This block is one cell of a programmable logic device. Two groups of product terms from the logic array are each ORed into a sum. Configuration bits then decide how those sums reach the cell's I/O pin. The sums can pass straight through as a combinational output. They can instead drive a single storage bit that behaves as a D, T, JK or SR flip-flop.

The storage bit has an active-low asynchronous clear. It is clocked either by the global clock or by a clock term produced in the array. The same configuration bit that picks the clock also picks the source of the pin's output enable. A pin that is configured as an input is never driven by the cell. A feedback path returns either the pin level or the cell's own value to the array. The array and the routing between cells sit outside this block.

Top module: `prog_macrocell`

## Requirements
- R1: With `cfg_bypass`=1 the cell value equals sum A, the OR of all bits of `pt_a`, combinationally and without a clock edge. With `cfg_bypass`=0 the cell value is the stored bit.
- R2: With `cfg_ff_type`=2'b00 (D) the stored bit takes sum A on each rising edge of the selected clock.
- R3: With `cfg_ff_type`=2'b01 (T) the stored bit inverts on a rising edge when sum A is 1, and holds when sum A is 0.
- R4: With `cfg_ff_type`=2'b10 (JK), where J is sum A and K is sum B (the OR of `pt_b`), a rising edge gives: J=K=0 hold, J=1 K=0 set, J=0 K=1 clear, J=K=1 invert.
- R5: With `cfg_ff_type`=2'b11 (SR), where S is sum A and R is sum B, a rising edge gives: S alone sets, R alone clears, neither holds, and both hold. `cfg_violation` is 1 exactly while SR mode has S=R=1, and 0 otherwise.
- R6: While `clr_n`=0 the stored bit is 0 at once, without a clock edge, and no clock edge changes it.
- R7: With `cfg_arr_clk`=0 the register is clocked by `clk_glb` and `pin_oe` follows `oe_term`. With `cfg_arr_clk`=1 the register is clocked by `clk_term` and `pin_oe` is 1. Edges on the clock that is not selected have no effect.
- R8: With `cfg_pin_in`=1, `pin_oe` and `pin_out` are both 0, whatever the other configuration and inputs are.
- R9: With `cfg_fb_pin`=1, `fb_out` equals `pin_in`. With `cfg_fb_pin`=0, `fb_out` equals the cell value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_glb | input | 1 | Global clock |
| clk_term | input | 1 | Clock term generated by the array |
| clr_n | input | 1 | Asynchronous clear, active low |
| pt_a | input | NT | Product terms ORed into sum A |
| pt_b | input | NT | Product terms ORed into sum B |
| oe_term | input | 1 | Output enable term from the array |
| pin_in | input | 1 | Level sensed at the I/O pin |
| cfg_ff_type | input | 2 | Register type: 00 D, 01 T, 10 JK, 11 SR |
| cfg_bypass | input | 1 | 1 selects the combinational output |
| cfg_arr_clk | input | 1 | Shared clock and output-enable select |
| cfg_pin_in | input | 1 | 1 reserves the pin as an input |
| cfg_fb_pin | input | 1 | 1 feeds the pin level back, 0 feeds the cell value |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Output enable of the pin driver |
| fb_out | output | 1 | Feedback returned to the array |
| cfg_violation | output | 1 | SR mode with S and R both high |

## Verification
The in-design assertions check, on every edge of the selected clock, the next-state rule of each register type. These rules are D capture, T inversion, JK inversion on J=K=1, and SR hold on a conflict. The bench scenarios check the behaviour the assertions do not cover. This covers the asynchronous clear between edges and edges on the clock that is not selected. It also covers the output-enable rules tied to the clock select, the override when the pin is an input, and both feedback sources, all observed at the ports.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'b00,
    FF_T  = 2'b01,
    FF_JK = 2'b10,
    FF_SR = 2'b11
  } ff_kind_e;
endpackage

// File: rtl/mc_sop_sum.sv
module mc_sop_sum #(
  parameter int NT = 8
) (
  input  logic [NT-1:0] terms,
  output logic          sum
);
  logic [NT:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NT; i++) begin : g_or
    assign chain[i+1] = chain[i] | terms[i];
  end
  assign sum = chain[NT];
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_pkg::*;
(
  input  ff_kind_e kind,
  input  logic     q,
  input  logic     in_a,
  input  logic     in_b,
  output logic     nxt,
  output logic     sr_conflict
);
  always_comb begin
    nxt         = q;
    sr_conflict = 1'b0;
    unique case (kind)
      FF_D:  nxt = in_a;
      FF_T:  nxt = in_a ? ~q : q;
      FF_JK: begin
        case ({in_a, in_b})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11:   nxt = ~q;
          default: nxt = q;
        endcase
      end
      FF_SR: begin
        case ({in_a, in_b})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11: begin
            nxt         = q;
            sr_conflict = 1'b1;
          end
          default: nxt = q;
        endcase
      end
      default: nxt = q;
    endcase
  end
endmodule

// File: rtl/mc_io_ctrl.sv
module mc_io_ctrl (
  input  logic cfg_arr_clk,
  input  logic cfg_pin_in,
  input  logic cfg_fb_pin,
  input  logic clk_glb,
  input  logic clk_term,
  input  logic oe_term,
  input  logic cell_val,
  input  logic pin_in,
  output logic cell_clk,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_out
);
  logic oe_raw;

  always_comb begin
    cell_clk = cfg_arr_clk ? clk_term : clk_glb;
    oe_raw   = cfg_arr_clk ? 1'b1 : oe_term;
    pin_oe   = cfg_pin_in ? 1'b0 : oe_raw;
    pin_out  = cfg_pin_in ? 1'b0 : cell_val;
    fb_out   = cfg_fb_pin ? pin_in : cell_val;
  end
endmodule

// File: rtl/prog_macrocell.sv
module prog_macrocell
  import mc_pkg::*;
#(
  parameter int NT = 8
) (
  input  logic          clk_glb,
  input  logic          clk_term,
  input  logic          clr_n,
  input  logic [NT-1:0] pt_a,
  input  logic [NT-1:0] pt_b,
  input  logic          oe_term,
  input  logic          pin_in,
  input  logic [1:0]    cfg_ff_type,
  input  logic          cfg_bypass,
  input  logic          cfg_arr_clk,
  input  logic          cfg_pin_in,
  input  logic          cfg_fb_pin,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          fb_out,
  output logic          cfg_violation
);
  logic     sum_a, sum_b;
  logic     q, q_nxt, cell_val, cell_clk;
  ff_kind_e kind;

  assign kind = ff_kind_e'(cfg_ff_type);

  mc_sop_sum #(.NT(NT)) u_sum_a (.terms(pt_a), .sum(sum_a));
  mc_sop_sum #(.NT(NT)) u_sum_b (.terms(pt_b), .sum(sum_b));

  mc_next_state u_nxt (
    .kind(kind), .q(q), .in_a(sum_a), .in_b(sum_b),
    .nxt(q_nxt), .sr_conflict(cfg_violation)
  );

  mc_io_ctrl u_io (
    .cfg_arr_clk(cfg_arr_clk), .cfg_pin_in(cfg_pin_in), .cfg_fb_pin(cfg_fb_pin),
    .clk_glb(clk_glb), .clk_term(clk_term), .oe_term(oe_term),
    .cell_val(cell_val), .pin_in(pin_in), .cell_clk(cell_clk),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  always_ff @(posedge cell_clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  assign cell_val = cfg_bypass ? sum_a : q;

  AST_D_CAPTURE: assert property (@(posedge cell_clk) disable iff (!clr_n)
    (kind == FF_D) |=> (q == $past(sum_a))); // R2
  AST_T_TOGGLE: assert property (@(posedge cell_clk) disable iff (!clr_n)
    (kind == FF_T && sum_a) |=> (q != $past(q))); // R3
  AST_JK_TOGGLE: assert property (@(posedge cell_clk) disable iff (!clr_n)
    (kind == FF_JK && sum_a && sum_b) |=> (q != $past(q))); // R4
  AST_SR_HOLD: assert property (@(posedge cell_clk) disable iff (!clr_n)
    (cfg_violation) |=> (q == $past(q))); // R5
endmodule

// File: tb/prog_macrocell_tb.sv
module prog_macrocell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;

  logic          clk_glb = 0, clk_term = 0, clr_n = 0;
  logic [NT-1:0] pt_a = '0, pt_b = '0;
  logic          oe_term = 0, pin_in = 0;
  logic [1:0]    cfg_ff_type = 2'b00;
  logic          cfg_bypass = 0, cfg_arr_clk = 0, cfg_pin_in = 0, cfg_fb_pin = 0;
  logic          pin_out, pin_oe, fb_out, cfg_violation;
  int            checks = 0, errors = 0;

  prog_macrocell #(.NT(NT)) u_dut (
    .clk_glb(clk_glb), .clk_term(clk_term), .clr_n(clr_n), .pt_a(pt_a), .pt_b(pt_b),
    .oe_term(oe_term), .pin_in(pin_in), .cfg_ff_type(cfg_ff_type),
    .cfg_bypass(cfg_bypass), .cfg_arr_clk(cfg_arr_clk), .cfg_pin_in(cfg_pin_in),
    .cfg_fb_pin(cfg_fb_pin), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out),
    .cfg_violation(cfg_violation)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_glb();
    #1 clk_glb = 1; #(CLK_PERIOD/2) clk_glb = 0; #(CLK_PERIOD/2);
  endtask

  task automatic pulse_term();
    #1 clk_term = 1; #(CLK_PERIOD/2) clk_term = 0; #(CLK_PERIOD/2);
  endtask

  task automatic set_ab(input logic a, input logic b);
    pt_a = a ? 8'b0010_0000 : '0;
    pt_b = b ? 8'b0000_0100 : '0;
  endtask

  task automatic do_clear();
    clr_n = 0; #2;
    pulse_glb();
    clr_n = 1; #2;
  endtask

  task automatic test_reset();
    #2 check("R6 reset value", pin_out, 1'b0);
    pulse_glb();
    check("R6 reset holds across edge", pin_out, 1'b0);
    clr_n = 1; #2;
    check("R5 no violation after reset", cfg_violation, 1'b0);
  endtask

  task automatic test_bypass();
    cfg_bypass = 1; pt_a = 8'b1000_0000; #2;
    check("R1 bypass high", pin_out, 1'b1);
    pt_a = '0; #2;
    check("R1 bypass low", pin_out, 1'b0);
    pt_a = 8'b0000_0001; #2;
    check("R1 bypass low bit", pin_out, 1'b1);
    cfg_bypass = 0; pt_a = '0; #2;
    check("R1 registered view", pin_out, 1'b0);
  endtask

  task automatic test_d();
    cfg_ff_type = 2'b00; set_ab(1, 0); pulse_glb();
    check("R2 D capture 1", pin_out, 1'b1);
    set_ab(0, 1); pulse_glb();
    check("R2 D capture 0", pin_out, 1'b0);
    set_ab(1, 0); pulse_term();
    check("R7 unselected clock ignored", pin_out, 1'b0);
  endtask

  task automatic test_t();
    do_clear(); cfg_ff_type = 2'b01;
    set_ab(1, 0); pulse_glb();
    check("R3 T toggle up", pin_out, 1'b1);
    pulse_glb();
    check("R3 T toggle down", pin_out, 1'b0);
    set_ab(0, 0); pulse_glb();
    check("R3 T hold", pin_out, 1'b0);
  endtask

  task automatic test_jk();
    do_clear(); cfg_ff_type = 2'b10;
    set_ab(1, 0); pulse_glb(); check("R4 JK set", pin_out, 1'b1);
    set_ab(0, 0); pulse_glb(); check("R4 JK hold", pin_out, 1'b1);
    set_ab(0, 1); pulse_glb(); check("R4 JK reset", pin_out, 1'b0);
    set_ab(1, 1); pulse_glb(); check("R4 JK toggle up", pin_out, 1'b1);
    pulse_glb();               check("R4 JK toggle down", pin_out, 1'b0);
  endtask

  task automatic test_sr();
    do_clear(); cfg_ff_type = 2'b11;
    set_ab(1, 0); pulse_glb(); check("R5 SR set", pin_out, 1'b1);
    check("R5 no flag on set", cfg_violation, 1'b0);
    set_ab(1, 1); #2;          check("R5 flag on conflict", cfg_violation, 1'b1);
    pulse_glb();               check("R5 conflict holds", pin_out, 1'b1);
    set_ab(0, 1); pulse_glb(); check("R5 SR reset", pin_out, 1'b0);
    set_ab(0, 0); pulse_glb(); check("R5 SR hold", pin_out, 1'b0);
    cfg_ff_type = 2'b10; set_ab(1, 1); #2;
    check("R5 no flag outside SR", cfg_violation, 1'b0);
    set_ab(0, 0);
  endtask

  task automatic test_clear();
    cfg_ff_type = 2'b00; set_ab(1, 0); pulse_glb();
    check("R6 preset for clear", pin_out, 1'b1);
    clr_n = 0; #2;
    check("R6 async clear", pin_out, 1'b0);
    pulse_glb();
    check("R6 clear beats edge", pin_out, 1'b0);
    clr_n = 1; #2; set_ab(0, 0);
  endtask

  task automatic test_clk_sel();
    cfg_arr_clk = 0; oe_term = 0; #2;
    check("R7 oe from term low", pin_oe, 1'b0);
    oe_term = 1; #2;
    check("R7 oe from term high", pin_oe, 1'b1);
    cfg_arr_clk = 1; oe_term = 0; #2;
    check("R7 oe forced on", pin_oe, 1'b1);
    cfg_ff_type = 2'b00; set_ab(1, 0); pulse_glb();
    check("R7 global clock ignored", pin_out, 1'b0);
    pulse_term();
    check("R7 array clock used", pin_out, 1'b1);
    set_ab(0, 0); pulse_term();
    cfg_arr_clk = 0;
  endtask

  task automatic test_pin_in();
    cfg_arr_clk = 1; oe_term = 1; cfg_bypass = 1; pt_a = 8'hFF; cfg_pin_in = 1; #2;
    check("R8 oe off for input", pin_oe, 1'b0);
    check("R8 pin not driven", pin_out, 1'b0);
    cfg_arr_clk = 0; #2;
    check("R8 oe off with term", pin_oe, 1'b0);
    cfg_pin_in = 0; cfg_bypass = 0; pt_a = '0; oe_term = 0; #2;
  endtask

  task automatic test_fb();
    cfg_fb_pin = 1; pin_in = 1; #2;
    check("R9 feedback pin high", fb_out, 1'b1);
    pin_in = 0; #2;
    check("R9 feedback pin low", fb_out, 1'b0);
    cfg_fb_pin = 0; pin_in = 0; cfg_ff_type = 2'b00; set_ab(1, 0); pulse_glb();
    check("R9 feedback internal", fb_out, 1'b1);
    cfg_bypass = 1; set_ab(0, 0); #2;
    check("R9 feedback bypass value", fb_out, 1'b0);
    cfg_bypass = 0;
  endtask

  initial begin
    test_reset();
    test_bypass();
    test_d();
    test_t();
    test_jk();
    test_sr();
    test_clear();
    test_clk_sel();
    test_pin_in();
    test_fb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule